// File: doc/BRIEF.md
# Register Rename Stage

This block sits between decode and issue in an out-of-order core. For every instruction it turns architectural register numbers into physical register numbers. The destination always receives a physical register taken from a pool of free ones. Two writes to the same architectural register therefore never share storage, so write-after-write and write-after-read hazards no longer apply. Both sources read the newest mapping of their architectural register, so true read-after-write dependencies still reach the correct producer.

The stage renames at most one instruction per cycle. Each instruction has two sources and one destination. When it renames an instruction, the stage also reports the physical register that the destination replaced. The core holds that number until the instruction retires in program order. The commit port then hands the number back, and the register returns to the free pool. When the pool is empty, the stage stalls renaming until a commit refills it.

Top module: `rename_stage`

## Requirements
- R1: After reset, architectural register i maps to physical register i for every i in 0..15, and renaming is ready.
- R2: After reset, the free pool holds physical registers 16 to 127. Renames without commits receive them in ascending order, starting at 16.
- R3: The source outputs give the current mapping of each source register. If a source equals the destination of the same instruction, the source gets the mapping in force before that rename.
- R4: The old-mapping output gives the physical register that the destination was mapped to just before the rename.
- R5: Two renames of the same architectural destination receive different physical registers, and a new destination never equals its own old mapping.
- R6: After 112 renames with no commits, `ren_ready` is low. A rename request made while it is low changes no mapping and consumes no register.
- R7: A committed register number joins the back of the free pool. Committed registers are reissued in the order they were committed, after all registers already in the pool.
- R8: A rename and a commit in the same cycle both take effect, and the pool size does not change. When the pool is empty, a commit in that cycle does not bypass to the rename: `ren_ready` stays low that cycle and rises in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ren_valid | input | 1 | An instruction requests renaming this cycle |
| ren_src_a | input | 4 | First source architectural register |
| ren_src_b | input | 4 | Second source architectural register |
| ren_dst | input | 4 | Destination architectural register |
| ren_ready | output | 1 | High when a free physical register is available |
| ren_psrc_a | output | 7 | Physical register for the first source |
| ren_psrc_b | output | 7 | Physical register for the second source |
| ren_pdst | output | 7 | Newly allocated physical register for the destination |
| ren_pold | output | 7 | Previous physical mapping of the destination |
| commit_valid | input | 1 | A retiring instruction releases a register |
| commit_pold | input | 7 | Physical register being released |

## Verification
Allocation and release can happen in the same cycle, and their interaction depends on how full the pool is. The bench provokes this in two ways. First, it empties the pool and then commits and requests a rename in the same cycle; it expects the stall to hold for that cycle and the committed register to be issued in the next one. Second, it runs a long stretch with one rename and one commit every cycle and a pool of one register; there each new destination must equal the register committed in the previous cycle. Expected mappings, old mappings and ready flags come from a reference pool and map kept in the bench.

// File: rtl/rename_pkg.sv
// Package: default sizes shared by the rename stage and its parts.
// Assumes the physical pool is larger than the architectural set.
package rename_pkg;
    localparam int unsigned ARCH_REGS_DEF = 16;
    localparam int unsigned PHYS_REGS_DEF = 128;
endpackage

// File: rtl/rename_map_table.sv
// Map table: one physical index per architectural register.
// Three read ports give combinational reads of the state before any update.
// One write port updates an entry at the clock edge.
// Assumes the writer only asserts wr_en for an accepted rename.
module rename_map_table #(
    parameter int unsigned NARCH = 16,
    parameter int unsigned NPHYS = 128,
    localparam int unsigned AW = $clog2(NARCH),
    localparam int unsigned PW = $clog2(NPHYS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_a_idx,
    input  logic [AW-1:0] rd_b_idx,
    input  logic [AW-1:0] rd_d_idx,
    output logic [PW-1:0] rd_a_phys,
    output logic [PW-1:0] rd_b_phys,
    output logic [PW-1:0] rd_d_phys,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [PW-1:0] wr_phys
);
    logic [PW-1:0] map_q [NARCH];

    // Reset to the identity mapping, otherwise apply the accepted rename.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NARCH; i++) begin
                map_q[i] <= PW'(i);
            end
        end else if (wr_en) begin
            map_q[wr_idx] <= wr_phys;
        end
    end

    // Read ports see the mapping in force before this cycle's write.
    always_comb begin
        rd_a_phys = map_q[rd_a_idx];
        rd_b_phys = map_q[rd_b_idx];
        rd_d_phys = map_q[rd_d_idx];
    end
endmodule

// File: rtl/rename_free_list.sv
// Free list: a circular FIFO of unused physical register numbers.
// After reset it holds NARCH..NPHYS-1 in ascending order.
// A push in the same cycle as a pop is fine.
// A pushed entry is not visible at the head until the next cycle.
// Assumes the caller never pops when empty and never pushes when full.
// Only registers that were once allocated come back, so it cannot overfill.
module rename_free_list #(
    parameter int unsigned NARCH = 16,
    parameter int unsigned NPHYS = 128,
    localparam int unsigned DEPTH = NPHYS - NARCH,
    localparam int unsigned PW = $clog2(NPHYS),
    localparam int unsigned IW = $clog2(DEPTH),
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pop,
    input  logic          push,
    input  logic [PW-1:0] push_phys,
    output logic [PW-1:0] head_phys,
    output logic          empty,
    output logic [CW-1:0] count
);
    logic [PW-1:0] slot_q [DEPTH];
    logic [IW-1:0] head_q;
    logic [IW-1:0] tail_q;
    logic [CW-1:0] count_q;

    // Advance a ring index with wrap at DEPTH.
    function automatic logic [IW-1:0] ring_next(input logic [IW-1:0] idx);
        return (idx == IW'(DEPTH - 1)) ? '0 : idx + 1'b1;
    endfunction

    // Fill the ring with the spare registers at reset, then track pushes and pops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                slot_q[i] <= PW'(NARCH + i);
            end
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= CW'(DEPTH);
        end else begin
            if (push) begin
                slot_q[tail_q] <= push_phys;
                tail_q         <= ring_next(tail_q);
            end
            if (pop) begin
                head_q <= ring_next(head_q);
            end
            count_q <= count_q + CW'(push) - CW'(pop);
        end
    end

    // Present the oldest free entry and the occupancy.
    always_comb begin
        head_phys = slot_q[head_q];
        empty     = (count_q == '0);
        count     = count_q;
    end
endmodule

// File: rtl/rename_stage.sv
// Rename stage top: combines the map table with the free list.
// It renames one instruction per cycle: two sources and one destination.
// It stalls while the free list is empty.
// It takes released registers back through an in-order commit port.
// Assumes commit_pold only ever carries an old mapping this stage handed out.
module rename_stage #(
    parameter int unsigned NARCH = rename_pkg::ARCH_REGS_DEF,
    parameter int unsigned NPHYS = rename_pkg::PHYS_REGS_DEF,
    localparam int unsigned AW = $clog2(NARCH),
    localparam int unsigned PW = $clog2(NPHYS),
    localparam int unsigned CW = $clog2(NPHYS - NARCH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ren_valid,
    input  logic [AW-1:0] ren_src_a,
    input  logic [AW-1:0] ren_src_b,
    input  logic [AW-1:0] ren_dst,
    output logic          ren_ready,
    output logic [PW-1:0] ren_psrc_a,
    output logic [PW-1:0] ren_psrc_b,
    output logic [PW-1:0] ren_pdst,
    output logic [PW-1:0] ren_pold,
    input  logic          commit_valid,
    input  logic [PW-1:0] commit_pold
);
    logic          fl_empty;
    logic [PW-1:0] fl_head;
    logic [CW-1:0] fl_count;
    logic          fire;

    // A rename is accepted only when a free register exists.
    always_comb begin
        fire      = ren_valid && !fl_empty;
        ren_ready = !fl_empty;
        ren_pdst  = fl_head;
    end

    rename_map_table #(.NARCH(NARCH), .NPHYS(NPHYS)) u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_a_idx  (ren_src_a),
        .rd_b_idx  (ren_src_b),
        .rd_d_idx  (ren_dst),
        .rd_a_phys (ren_psrc_a),
        .rd_b_phys (ren_psrc_b),
        .rd_d_phys (ren_pold),
        .wr_en     (fire),
        .wr_idx    (ren_dst),
        .wr_phys   (fl_head)
    );

    rename_free_list #(.NARCH(NARCH), .NPHYS(NPHYS)) u_free (
        .clk       (clk),
        .rst_n     (rst_n),
        .pop       (fire),
        .push      (commit_valid),
        .push_phys (commit_pold),
        .head_phys (fl_head),
        .empty     (fl_empty),
        .count     (fl_count)
    );
endmodule

// File: rtl/rename_checker.sv
// Checker for rename_stage. It relates the port handshakes to the free-list
// occupancy over time. It is attached to every rename_stage by the bind below.
module rename_checker #(
    parameter int unsigned NARCH = 16,
    parameter int unsigned NPHYS = 128,
    localparam int unsigned PW = $clog2(NPHYS),
    localparam int unsigned CW = $clog2(NPHYS - NARCH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ren_valid,
    input logic          ren_ready,
    input logic [PW-1:0] ren_pdst,
    input logic [PW-1:0] ren_pold,
    input logic          commit_valid,
    input logic [CW-1:0] fl_count
);
    logic acc;
    always_comb acc = ren_valid && ren_ready;

    // A new destination never reuses the register it replaces.
    p_fresh_dst_r5: assert property (@(posedge clk) disable iff (!rst_n)
        acc |-> (ren_pdst != ren_pold));

    // With no commit, a stall persists into the next cycle.
    p_stall_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ren_ready && !commit_valid) |=> !ren_ready);

    // A commit without a rename grows the pool by one.
    p_commit_grows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_valid && !acc) |=> (fl_count == $past(fl_count) + 1'b1));

    // The pool never holds more than the spare registers.
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fl_count <= CW'(NPHYS - NARCH));

    // A rename and a commit together leave the pool size unchanged.
    p_balance_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && commit_valid) |=> $stable(fl_count));
endmodule

bind rename_stage rename_checker #(.NARCH(NARCH), .NPHYS(NPHYS)) u_rename_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ren_valid    (ren_valid),
    .ren_ready    (ren_ready),
    .ren_pdst     (ren_pdst),
    .ren_pold     (ren_pold),
    .commit_valid (commit_valid),
    .fl_count     (fl_count)
);

// File: tb/test_rename_stage.sv
// Bench for rename_stage. A reference map and a reference free pool in the
// bench give the expected value of every output in every cycle.
module test_rename_stage;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ren_valid = 1'b0;
    logic [3:0] ren_src_a = '0, ren_src_b = '0, ren_dst = '0;
    logic       ren_ready;
    logic [6:0] ren_psrc_a, ren_psrc_b, ren_pdst, ren_pold;
    logic       commit_valid = 1'b0;
    logic [6:0] commit_pold = '0;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    int map_m [16];
    int fl_q [$];
    int ret_q [$];
    int seen [16];
    int got_pdst;

    always #2 clk = ~clk;

    rename_stage i_rename_stage (
        .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid), .ren_src_a(ren_src_a),
        .ren_src_b(ren_src_b), .ren_dst(ren_dst), .ren_ready(ren_ready),
        .ren_psrc_a(ren_psrc_a), .ren_psrc_b(ren_psrc_b), .ren_pdst(ren_pdst),
        .ren_pold(ren_pold), .commit_valid(commit_valid), .commit_pold(commit_pold)
    );

    task automatic chk(input string tag, input int got, input int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic chk_ne(input string tag, input int got, input int other);
        n_cmp++;
        if (got == other) begin
            n_bad++;
            $display("FAIL %s: got %0d expected a value other than %0d", tag, got, other);
        end
    endtask

    // One cycle: drive at the falling edge, compare 1 ns later, update the model.
    task automatic step(input bit v, input int sa, input int sb, input int d,
                        input bit cv, input int cp, input string tr, input string td);
        bit rdy;
        @(negedge clk);
        ren_valid = v; ren_src_a = 4'(sa); ren_src_b = 4'(sb); ren_dst = 4'(d);
        commit_valid = cv; commit_pold = 7'(cp);
        #1;
        rdy = (fl_q.size() > 0);
        chk(tr, int'(ren_ready), int'(rdy));
        got_pdst = int'(ren_pdst);
        if (v && rdy) begin
            chk("R3", int'(ren_psrc_a), map_m[sa]);
            chk("R3", int'(ren_psrc_b), map_m[sb]);
            chk(td, int'(ren_pdst), fl_q[0]);
            chk("R4", int'(ren_pold), map_m[d]);
            ret_q.push_back(map_m[d]);
            map_m[d] = fl_q[0];
            void'(fl_q.pop_front());
        end
        if (cv) fl_q.push_back(cp);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int cp;
        for (int i = 0; i < 16; i++) begin map_m[i] = i; seen[i] = -1; end
        for (int i = 16; i < 128; i++) fl_q.push_back(i);
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: identity mapping after reset, ready high.
        for (int i = 0; i < 16; i++) begin
            step(0, i, 15 - i, 0, 0, 0, "R1", "R1");
            chk("R1", int'(ren_psrc_a), i);
            chk("R1", int'(ren_psrc_b), 15 - i);
        end

        // R2/R3/R4/R5: drain the whole pool; each destination also appears as source a.
        for (int k = 0; k < 112; k++) begin
            int d;
            d = (k * 5) % 16;
            step(1, d, (k + 3) % 16, d, 0, 0, "R6", "R2");
            chk("R2", got_pdst, 16 + k);
            if (seen[d] >= 0) chk_ne("R5", got_pdst, seen[d]);
            seen[d] = got_pdst;
        end

        // R6: stalled request changes nothing.
        step(1, 0, 0, 0, 0, 0, "R6", "R6");
        step(0, 0, 0, 0, 0, 0, "R6", "R6");
        chk("R6", int'(ren_psrc_a), map_m[0]);
        chk("R6", int'(ren_ready), 0);

        // R8: commit while empty does not bypass; R7: it is reissued next cycle.
        cp = ret_q.pop_front();
        step(1, 1, 2, 3, 1, cp, "R8", "R8");
        chk("R8", int'(ren_ready), 0);
        step(1, 3, 4, 3, 0, 0, "R8", "R7");
        chk("R7", got_pdst, cp);

        // R7/R8: commits of several registers, then reissue in commit order.
        begin
            int order [6];
            for (int j = 0; j < 6; j++) begin
                order[j] = ret_q.pop_front();
                step(0, 0, 0, 0, 1, order[j], "R7", "R7");
            end
            for (int j = 0; j < 6; j++) begin
                step(1, j, j + 1, j + 7, 0, 0, "R7", "R7");
                chk("R7", got_pdst, order[j]);
            end
        end

        // R8: one rename and one commit per cycle, pool of one register.
        cp = ret_q.pop_front();
        step(0, 0, 0, 0, 1, cp, "R8", "R8");
        for (int k = 0; k < 300; k++) begin
            int expd;
            expd = fl_q[0];
            cp = ret_q.pop_front();
            step(1, k % 16, (k * 7) % 16, (k * 3) % 16, 1, cp, "R8", "R8");
            chk("R8", got_pdst, expd);
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule